// File: doc/BRIEF.md
# Line-Frequency BCD Calendar Counter

This block keeps the time of day and the calendar date without a crystal. Its time base is a slow digital tick taken from the mains frequency (50 Hz or 60 Hz). The tick is brought into the system clock domain and divided down to one pulse per second. Each second pulse advances a chain of BCD counters: seconds, minutes, hours (24-hour form), day of week, day of month, month, year, and a two-bit century field. The century field decides whether year 00 is a leap year.

Software sets the clock through a byte write port that covers register addresses 0 to 7. Any write to one of these addresses restarts the sub-second divider, so a newly written time starts on a full second. The value that software reads is a separate user copy, which is loaded from the running counters in a single cycle. While the bus logic holds the freeze input high, because a clock address is being read, that load is suspended, so a multi-byte read never sees a carry partway through. The block also drives a 1 Hz square wave, with push-pull and open-drain drive encodings.

Top module: `linefreq_rtc`

## Requirements
- R1: Bit 7 of address 5 selects the tick ratio. When it is 1 (the reset value), exactly 60 counted ticks make one second. When it is 0, 50 ticks make one second.
- R2: After reset, reading addresses 0 to 7 returns 00h, 00h, 00h, 00h, 01h, 81h, 01h, 00h, and the square-wave output enable is low.
- R3: The seconds field (address 1, bits 6:0) and the minutes field (address 2, bits 6:0) count in BCD from 00 to 59. The hours field (address 3, bits 5:0) counts from 00 to 23. Each field carries into the next field on wrap, including a carry from a ones digit of 9 into the tens digit.
- R4: At midnight the day of week (address 4, bits 2:0) steps from 7 back to 1 and the date advances. Month (address 6, bits 4:0) wraps from 12 to 01. Year (address 7) wraps from 99 to 00, and at that point the century field (address 6, bits 7:6) increments in binary.
- R5: The date (address 5, bits 5:0) rolls over to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. February ends at 29 in a leap year and at 28 otherwise. A year is a leap year when it is divisible by four. Year 00 counts as a leap year only when the century field is 0.
- R6: When bit 7 of address 1 (the stop bit) is 1, nothing counts. When it is written back to 0, counting resumes.
- R7: A write to any address from 0 to 7 clears the sub-second divider, so the next second needs a full tick ratio counted after the write.
- R8: While the freeze input is high, the readable registers keep their values. One cycle after freeze goes low, they show the current counters.
- R9: When the square-wave enable is 0, the output enable is low. When it is 1 in push-pull mode, the output enable is high and the output level is high for the first half of each second's tick count. In open-drain mode the output level is 0 and the output enable is high only during the low half of the second.
- R10: The tick input is synchronized and counted only on its rising edges, so a tick held high for many system clocks counts once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Asynchronous 50/60 Hz digital tick |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 3 | Clock register address 0 to 7 |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 3 | Read address into the user copy |
| rd_data | output | 8 | Read data from the user copy |
| freeze_i | input | 1 | High while a clock address is being read |
| cfg_we | input | 1 | Load square-wave configuration |
| cfg_sqw_en | input | 1 | Square-wave enable value to load |
| cfg_sqw_od | input | 1 | Open-drain select value to load |
| sqw_o | output | 1 | Square-wave output level |
| sqw_oe | output | 1 | Square-wave output enable |

## Verification
The hardest conditions to reach from the ports are the deep carries: midnight on the last day of December in year 99, and the end of February under each combination of leap rule and century field. The stimulus writes the registers to one second before each such boundary. Because the writes also clear the divider, exactly one tick ratio then lands the counters on the boundary, and the bench checks the date, month and century bytes. The freeze case is reached by raising freeze across a whole second and confirming that the user copy stays unchanged until freeze is released.

// File: rtl/lfrtc_pkg.sv
package lfrtc_pkg;

    typedef struct packed {
        logic       stop;
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hr;
        logic [2:0] dow;
        logic       sel_hi;
        logic [5:0] date;
        logic [1:0] cent;
        logic [4:0] mon;
        logic [7:0] yr;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        stop: 1'b0, sec: 7'h00, min: 7'h00, hr: 6'h00, dow: 3'd1,
        sel_hi: 1'b1, date: 6'h01, cent: 2'd0, mon: 5'h01, yr: 8'h00
    };

    // Next BCD value of a two-digit number
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return v + 8'd1;
    endfunction

    // Divisible-by-four test on a BCD year, with the century rule for 00
    function automatic logic is_leap(input logic [7:0] yr, input logic [1:0] cent);
        if (yr == 8'h00) return (cent == 2'd0);
        if (yr[4] == 1'b0) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] mon, input logic leap);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/lfrtc_tick_sync.sv
module lfrtc_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d    = q;
        d.s1 = tick_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.s2 & ~q.s3;

    // a rising edge is a single-cycle event
    p_rise_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/lfrtc_subsec_div.sv
module lfrtc_subsec_div #(
    parameter int DIV_LO = 50,
    parameter int DIV_HI = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic run_i,
    input  logic clr_i,
    input  logic sel_hi_i,
    output logic sec_o,
    output logic wave_o
);
    localparam int CW = $clog2(DIV_HI + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t d, q;
    logic [CW-1:0] lim;
    logic          wrap;

    assign lim  = sel_hi_i ? CW'(DIV_HI) : CW'(DIV_LO);
    assign wrap = rise_i && run_i && !clr_i && (q.cnt == lim - CW'(1));

    always_comb begin
        d = q;
        if (clr_i)              d.cnt = '0;
        else if (wrap)          d.cnt = '0;
        else if (rise_i && run_i) d.cnt = q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sec_o  = wrap;
    assign wave_o = (q.cnt < (lim >> 1));

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < lim);
    p_div_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (q.cnt == '0));
    p_sec_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o |-> rise_i);

endmodule

// File: rtl/lfrtc_cal_core.sv
module lfrtc_cal_core
    import lfrtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_i,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output cal_t       cal_o
);
    cal_t d, q;
    logic [5:0] last_day;

    assign last_day = month_last(q.mon, is_leap(q.yr, q.cent));

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_addr)
                3'd1: begin d.stop = wr_data[7]; d.sec = wr_data[6:0]; end
                3'd2: d.min = wr_data[6:0];
                3'd3: d.hr  = wr_data[5:0];
                3'd4: d.dow = wr_data[2:0];
                3'd5: begin d.sel_hi = wr_data[7]; d.date = wr_data[5:0]; end
                3'd6: begin d.cent = wr_data[7:6]; d.mon = wr_data[4:0]; end
                3'd7: d.yr  = wr_data;
                default: ;
            endcase
        end else if (sec_i && !q.stop) begin
            if (q.sec != 7'h59) d.sec = 7'(bcd_inc(8'(q.sec)));
            else begin
                d.sec = 7'h00;
                if (q.min != 7'h59) d.min = 7'(bcd_inc(8'(q.min)));
                else begin
                    d.min = 7'h00;
                    if (q.hr != 6'h23) d.hr = 6'(bcd_inc(8'(q.hr)));
                    else begin
                        d.hr  = 6'h00;
                        d.dow = (q.dow == 3'd7) ? 3'd1 : q.dow + 3'd1;
                        if (q.date != last_day) d.date = 6'(bcd_inc(8'(q.date)));
                        else begin
                            d.date = 6'h01;
                            if (q.mon != 5'h12) d.mon = 5'(bcd_inc(8'(q.mon)));
                            else begin
                                d.mon = 5'h01;
                                if (q.yr != 8'h99) d.yr = bcd_inc(q.yr);
                                else begin
                                    d.yr   = 8'h00;
                                    d.cent = q.cent + 2'd1;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CAL_RESET;
        else        q <= d;
    end

    assign cal_o = q;

    p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stop && !wr_en) |=> $stable(q));
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_i && !wr_en) |=> $stable(q));

endmodule

// File: rtl/linefreq_rtc.sv
module linefreq_rtc
    import lfrtc_pkg::*;
#(
    parameter int DIV_LO = 50,
    parameter int DIV_HI = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       freeze_i,
    input  logic       cfg_we,
    input  logic       cfg_sqw_en,
    input  logic       cfg_sqw_od,
    output logic       sqw_o,
    output logic       sqw_oe
);
    typedef struct packed {
        cal_t user;
        logic sqw_en;
        logic sqw_od;
    } top_t;

    localparam top_t TOP_RESET = '{user: CAL_RESET, sqw_en: 1'b0, sqw_od: 1'b0};

    top_t d, q;
    cal_t cal;
    logic rise, sec_pulse, wave;

    lfrtc_tick_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .rise_o (rise)
    );

    lfrtc_subsec_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .run_i    (!cal.stop),
        .clr_i    (wr_en),
        .sel_hi_i (cal.sel_hi),
        .sec_o    (sec_pulse),
        .wave_o   (wave)
    );

    lfrtc_cal_core u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_i   (sec_pulse),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cal_o   (cal)
    );

    always_comb begin
        d = q;
        if (!freeze_i) d.user = cal;
        if (cfg_we) begin
            d.sqw_en = cfg_sqw_en;
            d.sqw_od = cfg_sqw_od;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TOP_RESET;
        else        q <= d;
    end

    always_comb begin
        case (rd_addr)
            3'd1:    rd_data = {q.user.stop, q.user.sec};
            3'd2:    rd_data = {1'b0, q.user.min};
            3'd3:    rd_data = {2'b00, q.user.hr};
            3'd4:    rd_data = {5'b00000, q.user.dow};
            3'd5:    rd_data = {q.user.sel_hi, 1'b0, q.user.date};
            3'd6:    rd_data = {q.user.cent, 1'b0, q.user.mon};
            3'd7:    rd_data = q.user.yr;
            default: rd_data = 8'h00;
        endcase
    end

    always_comb begin
        if (!q.sqw_en)     begin sqw_o = 1'b0; sqw_oe = 1'b0;  end
        else if (q.sqw_od) begin sqw_o = 1'b0; sqw_oe = !wave; end
        else               begin sqw_o = wave; sqw_oe = 1'b1;  end
    end

    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(q.user));
    p_sqw_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !q.sqw_en |-> !sqw_oe);
    p_od_low_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sqw_en && q.sqw_od) |-> !sqw_o);

endmodule

// File: tb/sim_linefreq_rtc.sv
`timescale 1ns/1ps
module sim_linefreq_rtc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       freeze_i = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sqw_en = 1'b0;
    logic       cfg_sqw_od = 1'b0;
    logic       sqw_o, sqw_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [2:0] aq[$];
    logic [7:0] eq[$];
    string      tq[$];

    always #5 clk = ~clk;

    linefreq_rtc u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .freeze_i(freeze_i),
        .cfg_we(cfg_we), .cfg_sqw_en(cfg_sqw_en), .cfg_sqw_od(cfg_sqw_od),
        .sqw_o(sqw_o), .sqw_oe(sqw_oe)
    );

    // monitor: pops expected register reads and compares
    initial begin
        forever begin
            @(negedge clk);
            if (aq.size() != 0) begin
                rd_addr = aq[0];
                #1;
                total++;
                if (rd_data !== eq[0]) begin
                    bad++;
                    $display("FAIL %s addr=%0d actual=%02h expected=%02h", tq[0], aq[0], rd_data, eq[0]);
                end
                void'(aq.pop_front());
                void'(eq.pop_front());
                void'(tq.pop_front());
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        aq.push_back(a); eq.push_back(e); tq.push_back(tag);
        while (aq.size() != 0) step();
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1; repeat (4) step();
            tick_i = 1'b0; repeat (4) step();
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        step();
        wr_en = 1'b0;
        step();
    endtask

    task automatic cfg(input logic en, input logic od);
        cfg_we = 1'b1; cfg_sqw_en = en; cfg_sqw_od = od;
        step();
        cfg_we = 1'b0;
        step();
    endtask

    // one second before midnight on the given date, then one second (50 ticks)
    task automatic end_of_day(input logic [7:0] yr, input logic [7:0] cm, input logic [7:0] dt,
                              input logic [7:0] exp_dt, input logic [7:0] exp_cm, input string tag);
        wreg(3'd3, 8'h23); wreg(3'd2, 8'h59); wreg(3'd7, yr);
        wreg(3'd6, cm); wreg(3'd5, dt); wreg(3'd1, 8'h59);
        ticks(50);
        expect_reg(3'd5, exp_dt, tag);
        expect_reg(3'd6, exp_cm, tag);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) step();
        rst_n = 1'b1;
        step();

        // R2 reset values
        expect_reg(3'd0, 8'h00, "R2 reserved");
        expect_reg(3'd1, 8'h00, "R2 seconds");
        expect_reg(3'd3, 8'h00, "R2 hours");
        expect_reg(3'd4, 8'h01, "R2 day of week");
        expect_reg(3'd5, 8'h81, "R2 date with 60Hz select");
        expect_reg(3'd6, 8'h01, "R2 month");
        expect_reg(3'd7, 8'h00, "R2 year");
        check_bit(sqw_oe, 1'b0, "R2 sqw disabled");

        // R1 ratio 60
        ticks(59);
        expect_reg(3'd1, 8'h00, "R1 59 ticks not a second");
        ticks(1);
        expect_reg(3'd1, 8'h01, "R1 60th tick");

        // R10 long high counts once
        tick_i = 1'b1; repeat (200) step();
        tick_i = 1'b0; repeat (4) step();
        ticks(58);
        expect_reg(3'd1, 8'h01, "R10 long pulse counted once");
        ticks(1);
        expect_reg(3'd1, 8'h02, "R10 second after long pulse");

        // R1 ratio 50
        wreg(3'd5, 8'h01);
        expect_reg(3'd5, 8'h01, "R1 select cleared");
        ticks(49);
        expect_reg(3'd1, 8'h02, "R1 49 ticks at 50Hz");
        ticks(1);
        expect_reg(3'd1, 8'h03, "R1 50th tick");

        // R7 divider cleared by write
        ticks(25);
        wreg(3'd2, 8'h00);
        ticks(25);
        expect_reg(3'd1, 8'h03, "R7 divider restarted");
        ticks(25);
        expect_reg(3'd1, 8'h04, "R7 full ratio after write");

        // R3 digit carry without hour carry
        wreg(3'd3, 8'h05); wreg(3'd2, 8'h09); wreg(3'd1, 8'h59);
        ticks(50);
        expect_reg(3'd1, 8'h00, "R3 seconds wrap");
        expect_reg(3'd2, 8'h10, "R3 minute digit carry");
        expect_reg(3'd3, 8'h05, "R3 hour unchanged");

        // R4 full rollover at the end of a century
        wreg(3'd4, 8'h07); wreg(3'd7, 8'h99); wreg(3'd6, 8'h12);
        wreg(3'd5, 8'h31); wreg(3'd3, 8'h23); wreg(3'd2, 8'h59); wreg(3'd1, 8'h59);
        ticks(50);
        expect_reg(3'd1, 8'h00, "R3 seconds at midnight");
        expect_reg(3'd2, 8'h00, "R3 minutes at midnight");
        expect_reg(3'd3, 8'h00, "R3 hours wrap at 23");
        expect_reg(3'd4, 8'h01, "R4 day of week 7 to 1");
        expect_reg(3'd5, 8'h01, "R4 date to 01");
        expect_reg(3'd6, 8'h41, "R4 month to 01 and century 1");
        expect_reg(3'd7, 8'h00, "R4 year 99 to 00");

        // R5 month lengths and leap rule
        end_of_day(8'h00, 8'h02, 8'h28, 8'h29, 8'h02, "R5 year 00 century 0 leap");
        end_of_day(8'h00, 8'h42, 8'h28, 8'h01, 8'h43, "R5 year 00 century 1 not leap");
        end_of_day(8'h24, 8'h42, 8'h29, 8'h01, 8'h43, "R5 year 24 Feb 29 end");
        end_of_day(8'h23, 8'h02, 8'h28, 8'h01, 8'h03, "R5 year 23 Feb 28 end");
        end_of_day(8'h12, 8'h02, 8'h28, 8'h29, 8'h02, "R5 year 12 leap");
        end_of_day(8'h23, 8'h04, 8'h30, 8'h01, 8'h05, "R5 April 30 end");
        end_of_day(8'h23, 8'h01, 8'h30, 8'h31, 8'h01, "R5 January has 31");

        // R6 stop bit
        wreg(3'd1, 8'h90);
        ticks(100);
        expect_reg(3'd1, 8'h90, "R6 stopped");
        wreg(3'd1, 8'h10);
        ticks(50);
        expect_reg(3'd1, 8'h11, "R6 resumed");

        // R8 freeze
        freeze_i = 1'b1;
        ticks(50);
        expect_reg(3'd1, 8'h11, "R8 held while frozen");
        freeze_i = 1'b0;
        step(); step();
        expect_reg(3'd1, 8'h12, "R8 transfer after release");

        // R9 square wave (divider at 0 after the last second)
        cfg(1'b1, 1'b0);
        check_bit(sqw_oe, 1'b1, "R9 push-pull enable");
        check_bit(sqw_o, 1'b1, "R9 first half high");
        ticks(25);
        check_bit(sqw_o, 1'b0, "R9 second half low");
        cfg(1'b1, 1'b1);
        check_bit(sqw_oe, 1'b1, "R9 open-drain pulls low");
        check_bit(sqw_o, 1'b0, "R9 open-drain level");
        ticks(25);
        check_bit(sqw_oe, 1'b0, "R9 open-drain released in high half");
        cfg(1'b0, 1'b0);
        check_bit(sqw_oe, 1'b0, "R9 disabled");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule